// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block is one 8-bit general-purpose I/O port that sits on a small register bus. The bus has an address, a write strobe, write data and combinational read data. Software places a level on each pin through an output data register and picks the pin's direction through a direction register. It reads the pad levels back through a read-only pin-level register. That pin-level register has one special use: a write of ones to it inverts the chosen output data bits, so software can flip pins without a read-modify-write.

For each pin the block drives three signals toward an external pad: an output enable, an output value and a pull-up enable. It also samples the pad input through a two-flop synchronizer. A global pull-up kill input comes from a control register elsewhere in the chip and switches every pull-up off. A peripheral can take over any single pin through an override enable and its own drive signals. The other pins of the port keep working as plain I/O while that happens.

Top module: `gpio_port`

## Requirements
- R1: The address map is fixed. Address 0 is the output data register, address 1 is the direction register (1 = output) and address 2 is the pin-level register. Address 3 is unmapped. Read data is combinational from the addressed register.
- R2: The output data register and the direction register each read back the last value written to them.
- R3: The pin-level register reads the pad input levels after a two-flop synchronizer. A pad change made before clock edge k is readable after edge k+1. Writes never change the value it reads.
- R4: A write to the pin-level address inverts each output data bit whose write data bit is 1. Output data bits written as 0 keep their value, and the direction register is unchanged.
- R5: When a pin is not overridden, its output enable equals its direction bit and its output value equals its output data bit.
- R6: When a pin is not overridden, its pull-up is on only when its direction bit is 0, its data bit is 1 and the global pull-up kill input is 0.
- R7: When a pin's override enable is 1, its output enable and output value come from the override inputs and its pull-up is off. The registers and all non-overridden pins are unaffected.
- R8: Reset clears the output data and direction registers. All pins come up as inputs with their pull-ups off.
- R9: A write to the unmapped address changes no register, and a read from it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| pu_kill | input | 1 | Global pull-up disable |
| ovr_en | input | 8 | Per-pin peripheral override enable |
| ovr_oe | input | 8 | Peripheral output enable per pin |
| ovr_out | input | 8 | Peripheral output value per pin |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad driver enable per pin |
| pad_out | output | 8 | Pad output value per pin |
| pad_pu | output | 8 | Pad pull-up enable per pin |

## Verification
The pad outputs are direct logic of the registers. A wrong data or direction bit therefore shows up on `pad_oe`, `pad_out` or `pad_pu` in the cycle right after the write that caused it. A wrong toggle also appears one cycle after the write to the pin-level address. A synchronizer with a wrong depth shows as read data that arrives one clock too early or too late, so the bench samples exactly at the two-clock boundary. Override faults show only on the pins being overridden. A sweep that overrides some pins while driving the others through the registers reveals a fault that leaks from one group into the other.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         pu_kill,
  input  logic [W-1:0] ovr_en,
  input  logic [W-1:0] ovr_oe,
  input  logic [W-1:0] ovr_out,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_PIN  = 2'd2;

  logic [W-1:0] data_q, dir_q, sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DATA:  data_q <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_PIN:   data_q <= data_q ^ bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_DIR:   bus_rdata = dir_q;
      A_PIN:   bus_rdata = sync2_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_oe  = (ovr_en & ovr_oe)  | (~ovr_en & dir_q);
  assign pad_out = (ovr_en & ovr_out) | (~ovr_en & data_q);
  assign pad_pu  = ~ovr_en & ~dir_q & data_q & {W{~pu_kill}};

  // R4: toggle write flips selected data bits, direction stays
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PIN) |=> (data_q == ($past(data_q) ^ $past(bus_wdata))) && $stable(dir_q));

  // R9: unmapped write leaves both registers alone
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd3) |=> $stable(data_q) && $stable(dir_q));

  // R6: global kill removes every pull-up
  a_r6_kill: assert property (@(posedge clk) disable iff (!rst_n)
    pu_kill |-> pad_pu == '0);

  // R6/R7: a pin never pulls up while its driver is enabled
  a_r7_pu_vs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R3: synchronized input is not disturbed by bus writes
  a_r3_pin_path: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync2_q == $past(sync1_q));

  // R8: no write means registers hold
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(data_q) && $stable(dir_q));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  logic       clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       pu_kill = 0;
  logic [7:0] ovr_en = 0, ovr_oe = 0, ovr_out = 0, pad_in = 0;
  logic [7:0] pad_oe, pad_out, pad_pu;
  int tests = 0, fails = 0;
  logic [7:0] m_data, m_dir;

  always #2 clk = ~clk;

  gpio_port u_dut (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .pu_kill, .ovr_en, .ovr_oe, .ovr_out, .pad_in, .pad_oe, .pad_out, .pad_pu);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic chk_pads(input string tag);
    logic [7:0] e_oe, e_out, e_pu;
    e_oe  = (ovr_en & ovr_oe)  | (~ovr_en & m_dir);
    e_out = (ovr_en & ovr_out) | (~ovr_en & m_data);
    e_pu  = pu_kill ? 8'h00 : (~ovr_en & ~m_dir & m_data);
    #0.5;
    chk({tag, " oe"}, pad_oe, e_oe);
    chk({tag, " out"}, pad_out, e_out);
    chk({tag, " pu"}, pad_pu, e_pu);
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R8 reset state
    m_data = 0; m_dir = 0;
    chk_pads("R8 reset");
    rd(0, r); chk("R8 data reset", r, 8'h00);
    rd(1, r); chk("R8 dir reset", r, 8'h00);
    rst_n = 1;

    // R1 R2 R5 R6: sweep data values across direction patterns and kill
    for (int d = 0; d < 256; d += 17) begin
      for (int v = 0; v < 256; v++) begin
        wr(1, d[7:0]); wr(0, v[7:0]);
        m_dir = d[7:0]; m_data = v[7:0];
        pu_kill = v[0] ^ d[1];
        @(negedge clk);
        chk_pads("R5 R6 sweep");
        rd(0, r); chk("R2 R1 data readback", r, m_data);
        rd(1, r); chk("R2 R1 dir readback", r, m_dir);
      end
    end
    pu_kill = 0;

    // R4 toggle
    wr(1, 8'h0F); m_dir = 8'h0F;
    wr(0, 8'h5A); m_data = 8'h5A;
    for (int t = 0; t < 256; t += 7) begin
      wr(2, t[7:0]); m_data = m_data ^ t[7:0];
      rd(0, r); chk("R4 toggle data", r, m_data);
      rd(1, r); chk("R4 dir unchanged", r, m_dir);
      chk_pads("R4 pads");
    end
    wr(2, 8'h00);
    rd(0, r); chk("R4 zero write no change", r, m_data);

    // R3 sync latency and read-only
    for (int p = 0; p < 256; p += 13) begin
      @(negedge clk); pad_in = p[7:0];
      bus_addr = 2;
      @(negedge clk);
      rd(2, r); chk("R3 not yet visible", r, 8'(p - 13 < 0 ? 0 : p - 13));
      @(negedge clk);
      rd(2, r); chk("R3 after two clocks", r, p[7:0]);
    end
    wr(2, 8'hFF); m_data = ~m_data;
    rd(2, r); chk("R3 read-only", r, pad_in);

    // R9 unmapped
    wr(3, 8'hA5);
    rd(3, r); chk("R9 unmapped read", r, 8'h00);
    rd(0, r); chk("R9 data kept", r, m_data);
    rd(1, r); chk("R9 dir kept", r, m_dir);

    // R7 override sweep
    for (int e = 0; e < 256; e += 5) begin
      @(negedge clk);
      ovr_en = e[7:0]; ovr_oe = 8'(e * 3); ovr_out = ~e[7:0];
      wr(0, 8'(e + 1)); m_data = 8'(e + 1);
      wr(1, 8'(e * 7)); m_dir = 8'(e * 7);
      chk_pads("R7 override");
      rd(0, r); chk("R7 data untouched", r, m_data);
      rd(1, r); chk("R7 dir untouched", r, m_dir);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule